// File: doc/BRIEF.md
# Byte-FIFO Bus Bridge Register Block

This block is a slave on an 8-bit processor I/O bus. It gives the processor access to an external byte-wide asynchronous FIFO device that has one queue for each direction. The block claims a window of four consecutive I/O addresses. Strap inputs set the upper address bits of that window, and the two low address bits select one of four registers. A bus access to the data register is converted into exactly one pop strobe or one push strobe toward the FIFO device. A control/status register holds the interrupt masks and a general-purpose output bit, and it also shows the live queue flags. Writing any value to a third register requests an immediate flush of the transmit queue.

The FIFO device latches a push on the falling edge of its write strobe. The block therefore drives the data first, raises the strobe, and lowers it only after a parameterised number of clock cycles, so the data has that setup time before the latching edge. The flags from the device are asynchronous and pass through a synchronizer before any logic uses them. Interrupts are raised in two stages. Per-source masks form a visible request bit, and a global enable gates that bit onto the interrupt pin.

Top module: `fifo_bridge_regs`

## Requirements
- R1: An access is decoded only when `bus_sel` is high and `bus_addr[7:2]` equals `base_sel`; `bus_addr[1:0]` selects offset 0..3. A non-matching access changes no state, produces no strobe, and reads 0xFF.
- R2: A read of offset 0 returns `fifo_rdata`. After the read access ends, `fifo_pop` pulses high for exactly one clock, once per access however long the access lasts. There is no pop while the synchronized receive-empty flag is 1.
- R3: A write of offset 0 raises `fifo_wr_strobe` one clock after the access starts, with `fifo_wdata` already equal to the written byte and `fifo_wdata_oe` high. The strobe stays high for SETUP_CYC clocks and then falls. Data and `fifo_wdata_oe` stay valid through the fall and for HOLD_CYC clocks after it.
- R4: A write of offset 0 is ignored (no strobe) when the synchronized transmit-full flag is 1 or while a previous push sequence is still running.
- R5: A read of offset 1 returns the status byte: bit0 transmit full, bit1 global interrupt enable, bit2 transmit-space interrupt mask, bit3 receive-data interrupt mask, bit4 general-purpose output, bit5 general-purpose input, bit6 IRQ, bit7 receive empty.
- R6: A write of offset 1 updates only bits 1..4; the other bits ignore the written data. `fifo_gpio_out` follows bit 4.
- R7: Any write of offset 2 pulses `send_now` for exactly one clock, whatever the data. Reads of offsets 2 and 3 return 0xFF. A write of offset 3 has no effect.
- R8: IRQ (status bit 6) = (bit2 AND NOT transmit full) OR (bit3 AND NOT receive empty).
- R9: `irq_out` is high only when IRQ and the global enable (bit 1) are both 1.
- R10: Reset clears bits 1..4 and `fifo_gpio_out`.
- R11: While `fifo_link_ok` is low, the status reports transmit full = 1 and receive empty = 1.
- R12: A change on an asynchronous FIFO flag input becomes visible in the status after the second rising clock edge that follows it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low bus reset |
| base_sel | input | 6 | Strapped upper address bits of the register window |
| bus_addr | input | 8 | I/O address |
| bus_sel | input | 1 | I/O cycle qualifier |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data to the processor |
| irq_out | output | 1 | Gated interrupt request |
| fifo_rdata | input | 8 | Head byte of the receive queue |
| fifo_pop | output | 1 | One-clock pop pulse |
| fifo_wdata | output | 8 | Byte presented for a push |
| fifo_wdata_oe | output | 1 | Push data drive enable |
| fifo_wr_strobe | output | 1 | Push strobe, latched on its falling edge |
| send_now | output | 1 | One-clock flush request |
| fifo_tx_full | input | 1 | Asynchronous transmit-full flag |
| fifo_rx_empty | input | 1 | Asynchronous receive-empty flag |
| fifo_link_ok | input | 1 | Asynchronous device-connected flag |
| fifo_gpio_in | input | 1 | General-purpose input from the device |
| fifo_gpio_out | output | 1 | General-purpose output to the device |

## Verification
The bench drives the corner cases most likely to be wrong. It holds a read for several clocks, which a level-based pop would turn into several pops. It writes the data register while the queue is full, and again while a push is still in flight, and a wrong block would then emit an extra or corrupt strobe. It writes 0xFF to the status register, which exposes any read-only bit that is writable. It accesses an address outside the window, which a loose decoder would accept. It also times each flag change clock by clock, measures how long the strobe stays high, and checks that the data is still present at the falling edge, so an off-by-one in the setup counter or an extra synchronizer stage shows up as a wrong count.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

   localparam int OFF_W = 2;
   localparam int NREG  = 1 << OFF_W;
   localparam logic [7:0] JUNK_BYTE = 8'hFF;

   typedef enum logic [OFF_W-1:0] {
      OFF_DATA  = 2'd0,
      OFF_STAT  = 2'd1,
      OFF_FLUSH = 2'd2,
      OFF_SPARE = 2'd3
   } reg_off_e;

   typedef struct packed {
      logic rx_empty;
      logic irq;
      logic gpio_in;
      logic gpio_out;
      logic mask_rx;
      logic mask_tx;
      logic glob_en;
      logic tx_full;
   } stat_t;

   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_SETUP = 2'd1,
      PS_HOLD  = 2'd2
   } push_st_e;

endpackage

// File: rtl/fbr_sync.sv
module fbr_sync #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fbr_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("fbr_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d_async};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fbr_decode.sv
module fbr_decode
   import fbr_pkg::*;
#(
   parameter int ADDR_W = 8,
   localparam int BASE_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] base_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel,
   input  logic              rd,
   input  logic              wr,
   output logic [NREG-1:0]   rd_sel,
   output logic [NREG-1:0]   wr_evt,
   output logic              pop_evt
);

   logic            hit;
   logic [NREG-1:0] wr_now;
   logic [NREG-1:0] wr_q;
   logic [NREG-1:0] rd_q;

   assign hit = sel && (addr[ADDR_W-1:OFF_W] == base_sel);

   for (genvar k = 0; k < NREG; k++) begin : g_slot
      assign rd_sel[k] = hit && rd && (addr[OFF_W-1:0] == OFF_W'(k));
      assign wr_now[k] = hit && wr && (addr[OFF_W-1:0] == OFF_W'(k));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         wr_q <= wr_now;
         rd_q <= rd_sel;
      end
   end

   // write acts on the leading edge, pop on the trailing edge of a read
   assign wr_evt  = wr_now & ~wr_q;
   assign pop_evt = rd_q[OFF_DATA] & ~rd_sel[OFF_DATA];

   AST_WR_EVT_SINGLE : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_evt)); // R1

endmodule

// File: rtl/fbr_push.sv
module fbr_push
   import fbr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SETUP_CYC = 3,
   parameter int HOLD_CYC = 1,
   localparam int CNT_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC,
   localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] din,
   output logic              busy,
   output logic              strobe,
   output logic              oe,
   output logic [DATA_W-1:0] dout
);

   generate
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("fbr_push: SETUP_CYC must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("fbr_push: HOLD_CYC must be at least 1");
      end
   endgenerate

   push_st_e   st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= PS_IDLE;
         cnt  <= '0;
         dout <= '0;
      end else begin
         unique case (st)
            PS_IDLE: begin
               if (start) begin
                  st   <= PS_SETUP;
                  cnt  <= CNT_W'(SETUP_CYC - 1);
                  dout <= din;
               end
            end
            PS_SETUP: begin
               if (cnt == '0) begin
                  st  <= PS_HOLD;
                  cnt <= CNT_W'(HOLD_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PS_HOLD: begin
               if (cnt == '0) begin
                  st <= PS_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= PS_IDLE;
         endcase
      end
   end

   assign strobe = (st == PS_SETUP);
   assign oe     = (st != PS_IDLE);
   assign busy   = oe;

   // checker-side counter of strobe-high cycles
   logic [CNT_W:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_run <= '0;
      else if (strobe) hi_run <= hi_run + 1'b1;
      else hi_run <= '0;
   end

   AST_SETUP_WIDTH : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe) |-> hi_run == (CNT_W+1)'(SETUP_CYC)); // R3
   AST_DATA_AT_FALL : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe) |-> oe && $stable(dout)); // R3
   AST_DATA_STABLE_HIGH : assert property (@(posedge clk) disable iff (!rst_n)
      strobe && $past(strobe) |-> $stable(dout)); // R3

endmodule

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
   import fbr_pkg::*;
#(
   parameter int IRQ_REG = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stat,
   input  logic [7:0] wdata,
   input  logic       tx_full,
   input  logic       rx_empty,
   input  logic       gpio_in,
   output stat_t      stat,
   output logic       gpio_out,
   output logic       irq_out
);

   generate
      if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
         $error("fbr_ctrl: IRQ_REG must be 0 or 1");
      end
   endgenerate

   logic glob_en, mask_tx, mask_rx, gpo;
   logic irq_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en <= 1'b0;
         mask_tx <= 1'b0;
         mask_rx <= 1'b0;
         gpo     <= 1'b0;
      end else if (wr_stat) begin
         glob_en <= wdata[1];
         mask_tx <= wdata[2];
         mask_rx <= wdata[3];
         gpo     <= wdata[4];
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[7:5], wdata[0]};

   assign irq_bit = (mask_tx && !tx_full) || (mask_rx && !rx_empty);

   if (IRQ_REG != 0) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else irq_q <= glob_en && irq_bit;
      end
      assign irq_out = irq_q;
   end else begin : g_irq_comb
      assign irq_out = glob_en && irq_bit;
   end

   always_comb begin
      stat          = '0;
      stat.tx_full  = tx_full;
      stat.glob_en  = glob_en;
      stat.mask_tx  = mask_tx;
      stat.mask_rx  = mask_rx;
      stat.gpio_out = gpo;
      stat.gpio_in  = gpio_in;
      stat.irq      = irq_bit;
      stat.rx_empty = rx_empty;
   end

   assign gpio_out = gpo;

   AST_CTRL_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> $stable({glob_en, mask_tx, mask_rx, gpo})); // R6
   AST_IRQ_NEEDS_EN : assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en && $past(!glob_en) |-> !irq_out); // R9

endmodule

// File: rtl/fifo_bridge_regs.sv
module fifo_bridge_regs
   import fbr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SETUP_CYC = 3,
   parameter int HOLD_CYC = 1,
   parameter int IRQ_REG = 0,
   localparam int BASE_W = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] base_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_sel,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_out,
   input  logic [7:0]        fifo_rdata,
   output logic              fifo_pop,
   output logic [7:0]        fifo_wdata,
   output logic              fifo_wdata_oe,
   output logic              fifo_wr_strobe,
   output logic              send_now,
   input  logic              fifo_tx_full,
   input  logic              fifo_rx_empty,
   input  logic              fifo_link_ok,
   input  logic              fifo_gpio_in,
   output logic              fifo_gpio_out
);

   generate
      if (ADDR_W < OFF_W + 1) begin : g_bad_addr
         $error("fifo_bridge_regs: ADDR_W too small for the register window");
      end
   endgenerate

   // synchronized device flags
   logic txf_raw, rxe_raw, link_s, gpi_s;
   logic txf_s, rxe_s;

   fbr_sync #(
      .WIDTH  (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b0011)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async({fifo_link_ok, fifo_gpio_in, fifo_rx_empty, fifo_tx_full}),
      .q      ({link_s, gpi_s, rxe_raw, txf_raw})
   );

   assign txf_s = txf_raw || !link_s;
   assign rxe_s = rxe_raw || !link_s;

   // address decode and access edges
   logic [NREG-1:0] rd_sel;
   logic [NREG-1:0] wr_evt;
   logic            pop_evt;

   fbr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_sel(base_sel),
      .addr    (bus_addr),
      .sel     (bus_sel),
      .rd      (bus_rd),
      .wr      (bus_wr),
      .rd_sel  (rd_sel),
      .wr_evt  (wr_evt),
      .pop_evt (pop_evt)
   );

   // push sequencer
   logic push_busy;
   logic push_go;

   assign push_go = wr_evt[OFF_DATA] && !txf_s && !push_busy;

   fbr_push #(
      .DATA_W   (8),
      .SETUP_CYC(SETUP_CYC),
      .HOLD_CYC (HOLD_CYC)
   ) u_push (
      .clk   (clk),
      .rst_n (rst_n),
      .start (push_go),
      .din   (bus_wdata),
      .busy  (push_busy),
      .strobe(fifo_wr_strobe),
      .oe    (fifo_wdata_oe),
      .dout  (fifo_wdata)
   );

   // control / status
   stat_t stat;

   fbr_ctrl #(.IRQ_REG(IRQ_REG)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stat (wr_evt[OFF_STAT]),
      .wdata   (bus_wdata),
      .tx_full (txf_s),
      .rx_empty(rxe_s),
      .gpio_in (gpi_s),
      .stat    (stat),
      .gpio_out(fifo_gpio_out),
      .irq_out (irq_out)
   );

   // one-clock strobes
   logic pop_q, flush_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_q   <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         pop_q   <= pop_evt && !rxe_s;
         flush_q <= wr_evt[OFF_FLUSH];
      end
   end
   assign fifo_pop = pop_q;
   assign send_now = flush_q;

   // read mux: offsets 2 and 3 and misses return the junk byte
   always_comb begin
      bus_rdata = JUNK_BYTE;
      if (rd_sel[OFF_DATA]) bus_rdata = fifo_rdata;
      else if (rd_sel[OFF_STAT]) bus_rdata = stat;
   end

   logic unused_top;
   assign unused_top = ^{rd_sel[OFF_FLUSH], rd_sel[OFF_SPARE], wr_evt[OFF_SPARE]};

   AST_NO_PUSH_WHEN_FULL : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_wr_strobe) |-> !$past(txf_s)); // R4
   AST_FLUSH_PULSE : assert property (@(posedge clk) disable iff (!rst_n)
      send_now |=> !send_now); // R7
   AST_POP_PULSE : assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !fifo_pop); // R2
   AST_LINK_DOWN : assert property (@(posedge clk) disable iff (!rst_n)
      !link_s |-> stat.tx_full && stat.rx_empty); // R11
   AST_IRQ_PIN : assert property (@(posedge clk) disable iff (!rst_n)
      (IRQ_REG == 0) && irq_out |-> stat.irq && stat.glob_en); // R9

endmodule

// File: tb/fifo_bridge_regs_test.sv
module fifo_bridge_regs_test;

   localparam int SETUP = 3;
   localparam int HOLD  = 1;
   localparam logic [5:0] BASE = 6'b000011;
   localparam logic [7:0] A_DATA = {BASE, 2'd0};
   localparam logic [7:0] A_STAT = {BASE, 2'd1};
   localparam logic [7:0] A_FLSH = {BASE, 2'd2};
   localparam logic [7:0] A_SPAR = {BASE, 2'd3};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic irq_out;
   logic [7:0] fifo_rdata = 8'h00;
   logic fifo_pop;
   logic [7:0] fifo_wdata;
   logic fifo_wdata_oe, fifo_wr_strobe, send_now;
   logic fifo_tx_full = 1'b0, fifo_rx_empty = 1'b1, fifo_link_ok = 1'b1, fifo_gpio_in = 1'b0;
   logic fifo_gpio_out;

   always #4 clk = ~clk;

   fifo_bridge_regs #(.SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .base_sel(BASE), .bus_addr(bus_addr),
      .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out), .fifo_rdata(fifo_rdata),
      .fifo_pop(fifo_pop), .fifo_wdata(fifo_wdata), .fifo_wdata_oe(fifo_wdata_oe),
      .fifo_wr_strobe(fifo_wr_strobe), .send_now(send_now),
      .fifo_tx_full(fifo_tx_full), .fifo_rx_empty(fifo_rx_empty),
      .fifo_link_ok(fifo_link_ok), .fifo_gpio_in(fifo_gpio_in),
      .fifo_gpio_out(fifo_gpio_out)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model of the writable bits
   logic m_en = 0, m_itx = 0, m_irx = 0, m_gpo = 0;

   function automatic logic [7:0] exp_stat();
      logic tf, re, rq;
      tf = fifo_tx_full | ~fifo_link_ok;
      re = fifo_rx_empty | ~fifo_link_ok;
      rq = (m_itx & ~tf) | (m_irx & ~re);
      return {re, rq, fifo_gpio_in, m_gpo, m_irx, m_itx, m_en, tf};
   endfunction

   function automatic logic exp_irq();
      logic [7:0] s;
      s = exp_stat();
      return s[6] & m_en;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_sel = 1; bus_wr = 1;
      tick();
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [7:0] a, input int hold, output logic [7:0] d);
      bus_addr = a; bus_sel = 1; bus_rd = 1;
      #2 d = bus_rdata;
      @(negedge clk);
      repeat (hold) tick();
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic set_flags(input logic full, input logic empty, input logic link, input logic gpi);
      fifo_tx_full = full; fifo_rx_empty = empty; fifo_link_ok = link; fifo_gpio_in = gpi;
      repeat (3) tick();
   endtask

   task automatic stat_write(input logic [7:0] d);
      bus_write(A_STAT, d);
      m_en = d[1]; m_itx = d[2]; m_irx = d[3]; m_gpo = d[4];
   endtask

   // push observation
   int hi_cnt, rise_cnt;
   logic prev_stb;
   logic [7:0] fall_data;
   logic fall_oe;

   task automatic obs_clear();
      hi_cnt = 0; rise_cnt = 0; prev_stb = 0; fall_data = 8'h00; fall_oe = 0;
   endtask

   task automatic samp();
      if (fifo_wr_strobe && !prev_stb) rise_cnt++;
      if (fifo_wr_strobe) hi_cnt++;
      if (!fifo_wr_strobe && prev_stb) begin
         fall_data = fifo_wdata; fall_oe = fifo_wdata_oe;
      end
      prev_stb = fifo_wr_strobe;
   endtask

   task automatic observe(input int n);
      repeat (n) begin
         tick();
         samp();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      int pops;
      void'($urandom(32'd2718));
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (3) tick();

      // R10: reset state
      bus_read(A_STAT, 0, rd);
      chk("R10 reset status", rd, exp_stat());
      chk("R10 reset gpio_out", {7'd0, fifo_gpio_out}, 8'h00);
      chk("R10 reset irq_out", {7'd0, irq_out}, 8'h00);

      // R5/R6: write all ones, only bits 1..4 stick
      stat_write(8'hFF);
      bus_read(A_STAT, 0, rd);
      chk("R6 writable mask", rd, exp_stat());
      chk("R5 layout full-write", rd, {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0});
      chk("R6 gpio_out pin", {7'd0, fifo_gpio_out}, 8'h01);
      stat_write(8'h00);

      // R1: address outside the window
      bus_write({6'b010011, 2'd1}, 8'h1E);
      bus_read(A_STAT, 0, rd);
      chk("R1 miss no write", rd, exp_stat());
      bus_read({6'b010011, 2'd1}, 0, rd);
      chk("R1 miss reads junk", rd, 8'hFF);
      bus_addr = {6'b000111, 2'd2}; bus_sel = 1; bus_wr = 1;
      tick();
      chk("R1 miss no flush", {7'd0, send_now}, 8'h00);
      bus_sel = 0; bus_wr = 0;
      tick();

      // R7: flush pulse, junk reads, spare write
      bus_write(A_FLSH, 8'h5A);
      chk("R7 flush high", {7'd0, send_now}, 8'h01);
      tick();
      chk("R7 flush one cycle", {7'd0, send_now}, 8'h00);
      bus_write(A_FLSH, 8'h00);
      chk("R7 flush any value", {7'd0, send_now}, 8'h01);
      tick();
      bus_write(A_SPAR, 8'hFF);
      chk("R7 spare no flush", {7'd0, send_now}, 8'h00);
      bus_read(A_STAT, 0, rd);
      chk("R7 spare no state", rd, exp_stat());
      bus_read(A_FLSH, 0, rd);
      chk("R7 read flush junk", rd, 8'hFF);
      bus_read(A_SPAR, 0, rd);
      chk("R7 read spare junk", rd, 8'hFF);

      // R12: synchronizer latency
      bus_addr = A_STAT; bus_sel = 1; bus_rd = 1;
      fifo_rx_empty = 0;
      #2 chk("R12 before edges", bus_rdata[7], 8'h01);
      @(negedge clk); #2 chk("R12 after one edge", {7'd0, bus_rdata[7]}, 8'h01);
      @(negedge clk); #2 chk("R12 after two edges", {7'd0, bus_rdata[7]}, 8'h00);
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
      tick();

      // R3: push timing
      obs_clear();
      bus_write(A_DATA, 8'hC3);
      chk("R3 data at rise", fifo_wdata, 8'hC3);
      chk("R3 oe at rise", {7'd0, fifo_wdata_oe}, 8'h01);
      samp();
      observe(10);
      chk("R3 strobe width", 8'(hi_cnt), 8'(SETUP));
      chk("R3 single rise", 8'(rise_cnt), 8'h01);
      chk("R3 data at fall", fall_data, 8'hC3);
      chk("R3 oe at fall", {7'd0, fall_oe}, 8'h01);
      chk("R3 oe released", {7'd0, fifo_wdata_oe}, 8'h00);

      // R4: write while busy dropped
      obs_clear();
      bus_write(A_DATA, 8'h11);
      samp();
      bus_write(A_DATA, 8'h22);
      samp();
      observe(12);
      chk("R4 busy one push", 8'(rise_cnt), 8'h01);
      chk("R4 busy keeps first data", fall_data, 8'h11);

      // R4: write while full dropped
      set_flags(1, 0, 1, 0);
      obs_clear();
      bus_write(A_DATA, 8'h77);
      samp();
      observe(8);
      chk("R4 full no strobe", 8'(rise_cnt), 8'h00);
      set_flags(0, 0, 1, 0);

      // R2: read data and single pop even for a long access
      fifo_rdata = 8'hA5;
      bus_read(A_DATA, 3, rd);
      chk("R2 read data", rd, 8'hA5);
      chk("R2 no pop during access", {7'd0, fifo_pop}, 8'h00);
      tick();
      chk("R2 pop pulse", {7'd0, fifo_pop}, 8'h01);
      pops = 0;
      repeat (5) begin tick(); if (fifo_pop) pops++; end
      chk("R2 single pop", 8'(pops), 8'h00);
      set_flags(0, 1, 1, 0);
      pops = 0;
      bus_read(A_DATA, 0, rd);
      repeat (4) begin tick(); if (fifo_pop) pops++; end
      chk("R2 no pop when empty", 8'(pops), 8'h00);

      // R8/R9: interrupt combinations
      set_flags(0, 1, 1, 0);
      stat_write(8'h04);
      bus_read(A_STAT, 0, rd);
      chk("R8 tx space irq bit", rd, exp_stat());
      chk("R9 irq gated off", {7'd0, irq_out}, 8'h00);
      stat_write(8'h06);
      chk("R9 irq on", {7'd0, irq_out}, 8'h01);
      set_flags(1, 1, 1, 0);
      chk("R8 full drops irq", {7'd0, irq_out}, 8'h00);
      stat_write(8'h0A);
      set_flags(1, 0, 1, 0);
      chk("R8 rx data irq", {7'd0, irq_out}, {7'd0, exp_irq()});

      // R11: link down
      set_flags(0, 0, 0, 1);
      bus_read(A_STAT, 0, rd);
      chk("R11 link down status", rd & 8'h81, 8'h81);
      chk("R11 link down full", rd, exp_stat());
      obs_clear();
      bus_write(A_DATA, 8'h3C);
      samp();
      observe(6);
      chk("R11 link down no push", 8'(rise_cnt), 8'h00);
      set_flags(0, 1, 1, 0);

      // random mix
      for (int i = 0; i < 300; i++) begin
         int op;
         op = $urandom_range(0, 2);
         if (op == 0) begin
            stat_write(8'($urandom));
         end else if (op == 1) begin
            set_flags(1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0), 1'($urandom));
         end
         bus_read(A_STAT, 0, rd);
         chk("R5 R8 random status", rd, exp_stat());
         chk("R9 random irq", {7'd0, irq_out}, {7'd0, exp_irq()});
      end

      // R10: reset during operation
      stat_write(8'h1E);
      rst_n = 0;
      m_en = 0; m_itx = 0; m_irx = 0; m_gpo = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      repeat (3) tick();
      bus_read(A_STAT, 0, rd);
      chk("R10 reset clears ctrl", rd & 8'h1E, 8'h00);
      chk("R10 reset gpio pin", {7'd0, fifo_gpio_out}, 8'h00);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule